// File: doc/BRIEF.md
# Local Memory Access Steering Unit

This unit sits between a processor's local bus and three places that can return data: an on-chip SRAM window, a cache controller, and system memory. On a read it enables the SRAM and the cache lookup in the same cycle. One cycle later it picks the answer by fixed priority. A hit in the SRAM window wins, and anything the cache returned is dropped. Failing that, a cache hit is used. If both miss, a system-memory request is raised and held until the acknowledge arrives. The returned word is then passed to the processor together with a cache-fill strobe.

Writes work differently. The address is decoded against the local map first, and only the one target that the decode selects is enabled. The SRAM window is 4 KB long, and its placement is set by a base register. That register holds a 4 KB-aligned base, a valid flag and two mask flags, one for instruction fetches and one for data accesses. A class that is masked never enables the SRAM, which saves power. Addresses inside the window are never handed to the cache for allocation. After reset the window is invalid, so all traffic takes the cache and system-memory path.

Top module: `lmem_steer`

## Requirements
- R1: On an accepted read, `cache_en` is high in the request cycle. `sram_en` is high in that same cycle whenever the window is valid and the access class is not masked, whether or not the address matches.
- R2: When a read falls in the active window, `rsp_ready` is high one cycle after the request, `rsp_data` equals `sram_rdata`, and `sys_req` stays low. This holds even if `cache_hit` is high in that cycle.
- R3: When a read misses the window but `cache_hit` is high one cycle after the request, `rsp_ready` is high in that cycle and `rsp_data` equals `cache_rdata`.
- R4: `cache_alloc_ok` is low during a request whose address lies in the active window, and high otherwise. `cache_fill_en` is never raised for a read that the window served.
- R5: An accepted write enables exactly one target with `mem_we` high. That target is `sram_en` when the address lies in the active window for data accesses, and `cache_en` otherwise.
- R6: An address lies in the window when bits [31:12] equal the base field and the valid flag is set. Bits [11:0] are passed on unchanged as `mem_addr`.
- R7: With `cfg_mask_ifetch` set, instruction fetches (`req_ifetch`=1) treat the window as absent. With `cfg_mask_data` set, data reads and writes treat it as absent. The other class is not affected.
- R8: When a read misses both sources, `sys_req` rises one cycle after the request and stays high, with `sys_addr` equal to the read address, until `sys_ack`. Until then `rsp_ready` and `req_ready` are low.
- R9: In the cycle that `sys_req` and `sys_ack` are both high, `rsp_ready` and `cache_fill_en` are high and `rsp_data` equals `sys_rdata`. In the next cycle `sys_req` is low.
- R10: After reset the window is invalid, so reads are served from the cache path and `sram_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the window register |
| cfg_base | input | 20 | Window base, address bits [31:12] |
| cfg_valid | input | 1 | Window enable |
| cfg_mask_ifetch | input | 1 | Hide the window from instruction fetches |
| cfg_mask_data | input | 1 | Hide the window from data accesses |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ifetch | input | 1 | 1 = instruction fetch |
| req_addr | input | 32 | Access address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| mem_addr | output | 32 | Address to SRAM and cache |
| mem_wdata | output | 32 | Write data to SRAM and cache |
| mem_we | output | 1 | Write strobe qualifying the enables |
| sram_en | output | 1 | SRAM enable |
| cache_en | output | 1 | Cache controller enable |
| cache_alloc_ok | output | 1 | Miss of this access may be allocated |
| sram_rdata | input | 32 | SRAM data, one cycle after enable |
| cache_hit | input | 1 | Cache hit, one cycle after enable |
| cache_rdata | input | 32 | Cache data, one cycle after enable |
| sys_req | output | 1 | System-memory read request |
| sys_addr | output | 32 | System-memory read address |
| sys_ack | input | 1 | System-memory data valid |
| sys_rdata | input | 32 | System-memory data |
| rsp_ready | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| cache_fill_en | output | 1 | Write returned word into cache |

## Verification
The lookup cycle is where two functions collide. The SRAM return and the cache hit can arrive together, and the bench provokes this by holding `cache_hit` high while reading from inside the window. The result is judged by the data value and by a low `sys_req` and `cache_fill_en`. A second case comes when the acknowledge arrives in the same cycle as the miss is detected: the bench expects the response and the fill strobe right then, and no further request after it. While a miss is outstanding, a new request is driven to confirm it is refused.

// File: rtl/lmem_pkg.sv
package lmem_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int WIN_LOG2   = 12;
    localparam int BASE_W     = ADDR_W - WIN_LOG2;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              valid;
        logic              mask_ifetch;
        logic              mask_data;
    } win_cfg_t;

    localparam win_cfg_t WIN_CFG_RESET = '{base: '0, valid: 1'b0,
                                           mask_ifetch: 1'b0, mask_data: 1'b0};

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SRAM  = 2'd1,
        SRC_CACHE = 2'd2,
        SRC_SYS   = 2'd3
    } rd_src_e;

    function automatic logic class_open(win_cfg_t c, logic ifetch);
        return c.valid && !(ifetch ? c.mask_ifetch : c.mask_data);
    endfunction

    function automatic logic addr_in_win(win_cfg_t c, logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:WIN_LOG2] == c.base;
    endfunction
endpackage

// File: rtl/lmem_win_reg.sv
module lmem_win_reg
    import lmem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  win_cfg_t cfg_in,
    output win_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)       cfg_q <= WIN_CFG_RESET;
        else if (load) cfg_q <= cfg_in;
    end

    AST_RESET_INVALID: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cfg_q.valid); // R10
endmodule

// File: rtl/lmem_win_dec.sv
module lmem_win_dec
    import lmem_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ifetch,
    output logic              open,
    output logic              hit
);
    always_comb begin
        open = class_open(cfg, ifetch);
        hit  = open && addr_in_win(cfg, addr);
    end
endmodule

// File: rtl/lmem_rd_ctl.sv
module lmem_rd_ctl
    import lmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_fire,
    input  logic              rd_sram,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              cache_hit,
    input  logic [DATA_W-1:0] sram_rdata,
    input  logic [DATA_W-1:0] cache_rdata,
    input  logic              sys_ack,
    input  logic [DATA_W-1:0] sys_rdata,
    output logic              sys_req,
    output logic [ADDR_W-1:0] sys_addr,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fill_en,
    output logic              busy
);
    logic              look_q;
    logic              sram_q;
    logic              wait_q;
    logic [ADDR_W-1:0] addr_q;
    logic              miss_now;
    rd_src_e           src;

    always_comb begin
        miss_now = look_q && !sram_q && !cache_hit;
        sys_req  = miss_now || wait_q;
        busy     = sys_req;
        sys_addr = addr_q;
        if (look_q && sram_q)        src = SRC_SRAM;
        else if (look_q && cache_hit) src = SRC_CACHE;
        else if (sys_req && sys_ack)  src = SRC_SYS;
        else                          src = SRC_NONE;
        rsp_ready = (src != SRC_NONE);
        fill_en   = (src == SRC_SYS);
        case (src)
            SRC_SRAM:  rsp_data = sram_rdata;
            SRC_CACHE: rsp_data = cache_rdata;
            SRC_SYS:   rsp_data = sys_rdata;
            default:   rsp_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            look_q <= 1'b0;
            sram_q <= 1'b0;
            wait_q <= 1'b0;
            addr_q <= '0;
        end else begin
            look_q <= rd_fire;
            wait_q <= sys_req && !sys_ack;
            if (rd_fire) begin
                sram_q <= rd_sram;
                addr_q <= rd_addr;
            end
        end
    end

    AST_SRAM_FIRST: assert property (@(posedge clk) disable iff (rst)
        rd_fire && rd_sram |=> rsp_ready && !sys_req && !fill_en); // R2
    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        sys_req && !sys_ack |=> sys_req && $stable(sys_addr)); // R8
    AST_MISS_NO_READY: assert property (@(posedge clk) disable iff (rst)
        sys_req && !sys_ack |-> !rsp_ready); // R8
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        sys_req && sys_ack |=> !sys_req); // R9
endmodule

// File: rtl/lmem_steer.sv
module lmem_steer
    import lmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic              cfg_valid,
    input  logic              cfg_mask_ifetch,
    input  logic              cfg_mask_data,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_ifetch,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              sram_en,
    output logic              cache_en,
    output logic              cache_alloc_ok,
    input  logic [DATA_W-1:0] sram_rdata,
    input  logic              cache_hit,
    input  logic [DATA_W-1:0] cache_rdata,
    output logic              sys_req,
    output logic [ADDR_W-1:0] sys_addr,
    input  logic              sys_ack,
    input  logic [DATA_W-1:0] sys_rdata,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              cache_fill_en
);
    win_cfg_t cfg_in;
    win_cfg_t cfg_q;
    logic     win_open;
    logic     win_hit;
    logic     busy;
    logic     fire;
    logic     rd_fire;
    logic     wr_fire;

    assign cfg_in = '{base: cfg_base, valid: cfg_valid,
                      mask_ifetch: cfg_mask_ifetch, mask_data: cfg_mask_data};

    lmem_win_reg i_win_reg (
        .clk    (clk),
        .rst    (rst),
        .load   (cfg_we),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    lmem_win_dec i_win_dec (
        .cfg    (cfg_q),
        .addr   (req_addr),
        .ifetch (req_ifetch && !req_write),
        .open   (win_open),
        .hit    (win_hit)
    );

    always_comb begin
        req_ready      = !busy;
        fire           = req_valid && req_ready;
        rd_fire        = fire && !req_write;
        wr_fire        = fire && req_write;
        mem_addr       = req_addr;
        mem_wdata      = req_wdata;
        mem_we         = wr_fire;
        // reads: speculative parallel lookup; writes: decoded single target
        sram_en        = (rd_fire && win_open) || (wr_fire && win_hit);
        cache_en       = rd_fire || (wr_fire && !win_hit);
        cache_alloc_ok = fire && !win_hit;
    end

    lmem_rd_ctl i_rd_ctl (
        .clk         (clk),
        .rst         (rst),
        .rd_fire     (rd_fire),
        .rd_sram     (win_hit),
        .rd_addr     (req_addr),
        .cache_hit   (cache_hit),
        .sram_rdata  (sram_rdata),
        .cache_rdata (cache_rdata),
        .sys_ack     (sys_ack),
        .sys_rdata   (sys_rdata),
        .sys_req     (sys_req),
        .sys_addr    (sys_addr),
        .rsp_ready   (rsp_ready),
        .rsp_data    (rsp_data),
        .fill_en     (cache_fill_en),
        .busy        (busy)
    );

    AST_PAR_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !req_write |-> cache_en); // R1
    AST_WR_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_write |-> $onehot({sram_en, cache_en}) && mem_we); // R5
    AST_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        sram_en && mem_we |-> !cache_alloc_ok); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !sram_en && !cache_en && !mem_we); // R5
endmodule

// File: tb/test_lmem_steer.sv
module test_lmem_steer;
    localparam logic [31:0] D_SRAM  = 32'h5A5A_0001;
    localparam logic [31:0] D_CACHE = 32'hCAC4_0002;
    localparam logic [31:0] D_SYS   = 32'h5150_0003;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 0, cfg_valid = 0, cfg_mask_ifetch = 0, cfg_mask_data = 0;
    logic [19:0] cfg_base = '0;
    logic        req_valid = 0, req_write = 0, req_ifetch = 0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, mem_we, sram_en, cache_en, cache_alloc_ok;
    logic [31:0] mem_addr, mem_wdata, sys_addr, rsp_data;
    logic        cache_hit = 0, sys_ack = 0;
    logic        sys_req, rsp_ready, cache_fill_en;
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    lmem_steer i_lmem_steer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
        .cfg_valid(cfg_valid), .cfg_mask_ifetch(cfg_mask_ifetch),
        .cfg_mask_data(cfg_mask_data), .req_valid(req_valid),
        .req_write(req_write), .req_ifetch(req_ifetch), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .sram_en(sram_en),
        .cache_en(cache_en), .cache_alloc_ok(cache_alloc_ok),
        .sram_rdata(D_SRAM), .cache_hit(cache_hit), .cache_rdata(D_CACHE),
        .sys_req(sys_req), .sys_addr(sys_addr), .sys_ack(sys_ack),
        .sys_rdata(D_SYS), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .cache_fill_en(cache_fill_en)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic t_cfg(logic [19:0] b, logic v, logic mi, logic md);
        @(negedge clk);
        cfg_we = 1; cfg_base = b; cfg_valid = v; cfg_mask_ifetch = mi; cfg_mask_data = md;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // kind: 0 = served by SRAM, 1 = cache, 2 = system memory
    task automatic t_read(string req, logic [31:0] a, logic ifch, logic ch,
                          int kind, int waits, logic exp_sram_en);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_ifetch = ifch; req_addr = a;
        #1;
        chk("R1", "cache_en at request", cache_en, 1);
        chk(req, "sram_en at request", sram_en, exp_sram_en);
        chk("R6", "mem_addr", mem_addr, a);
        chk("R4", "cache_alloc_ok", cache_alloc_ok, (kind != 0));
        @(negedge clk);
        req_valid = 0; cache_hit = ch;
        if (kind == 2 && waits == 0) sys_ack = 1;
        #1;
        if (kind == 0) begin
            chk(req, "ready on window hit", rsp_ready, 1);
            chk("R2", "data from SRAM", rsp_data, D_SRAM);
            chk("R2", "no sys_req", sys_req, 0);
            chk("R4", "no fill", cache_fill_en, 0);
        end else if (kind == 1) begin
            chk(req, "ready on cache hit", rsp_ready, 1);
            chk("R3", "data from cache", rsp_data, D_CACHE);
            chk("R3", "no sys_req", sys_req, 0);
        end else begin
            chk("R8", "sys_req after miss", sys_req, 1);
            chk("R8", "sys_addr", sys_addr, a);
            if (waits == 0) begin
                chk("R9", "ready with ack in lookup", rsp_ready, 1);
                chk("R9", "fill with ack in lookup", cache_fill_en, 1);
                chk("R9", "data from system", rsp_data, D_SYS);
            end else begin
                chk("R8", "no ready while waiting", rsp_ready, 0);
                cache_hit = 0;
                for (int i = 0; i < waits; i++) begin
                    @(negedge clk);
                    req_valid = 1; req_addr = 32'h0000_0040; req_write = 0; req_ifetch = 0;
                    #1;
                    chk("R8", "sys_req held", sys_req, 1);
                    chk("R8", "req refused while waiting", req_ready, 0);
                    chk("R8", "no ready while waiting", rsp_ready, 0);
                    chk("R8", "sys_addr held", sys_addr, a);
                end
                @(negedge clk);
                req_valid = 0; sys_ack = 1;
                #1;
                chk("R9", "ready on ack", rsp_ready, 1);
                chk("R9", "fill on ack", cache_fill_en, 1);
                chk("R9", "data from system", rsp_data, D_SYS);
            end
        end
        @(negedge clk);
        sys_ack = 0; cache_hit = 0;
        #1;
        chk(req, "no pending sys_req", sys_req, 0);
        chk(req, "req_ready back", req_ready, 1);
    endtask

    task automatic t_write(string req, logic [31:0] a, logic to_sram);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_ifetch = 0; req_addr = a; req_wdata = ~a;
        #1;
        chk(req, "write sram_en", sram_en, to_sram);
        chk(req, "write cache_en", cache_en, !to_sram);
        chk("R5", "mem_we", mem_we, 1);
        chk("R5", "mem_wdata", mem_wdata, ~a);
        chk("R4", "alloc on write", cache_alloc_ok, !to_sram);
        @(negedge clk);
        req_valid = 0; req_write = 0;
        #1;
        chk("R5", "no read response after write", rsp_ready, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R10", "reset rsp_ready", rsp_ready, 0);
        chk("R10", "reset sys_req", sys_req, 0);
        // R10: window invalid after reset, region address goes via cache
        t_read("R10", 32'h0000_0010, 0, 1, 1, 0, 0);
        t_read("R10", 32'h0000_0020, 0, 0, 2, 1, 0);
        // R2, R6: window at 0x0002_0000
        t_cfg(20'h00020, 1, 0, 0);
        t_read("R2", 32'h0002_0004, 0, 1, 0, 0, 1);
        t_read("R6", 32'h0002_0FFC, 0, 0, 0, 0, 1);
        t_read("R6", 32'h0002_1000, 0, 1, 1, 0, 1);
        t_read("R3", 32'h0001_FFFC, 1, 1, 1, 0, 1);
        // R8, R9: misses with three waits and with immediate ack
        t_read("R8", 32'h0001_FFF8, 0, 0, 2, 3, 1);
        t_read("R9", 32'h0003_0000, 0, 0, 2, 0, 1);
        // R5: writes
        t_write("R5", 32'h0002_0008, 1);
        t_write("R5", 32'h0003_0008, 0);
        // R7: instruction fetches masked, data reads still hit
        t_cfg(20'h00020, 1, 1, 0);
        t_read("R7", 32'h0002_0010, 1, 1, 1, 0, 0);
        t_read("R7", 32'h0002_0010, 0, 1, 0, 0, 1);
        // R7: data masked, fetch hits, data write goes to cache
        t_cfg(20'h00020, 1, 0, 1);
        t_read("R7", 32'h0002_0014, 0, 0, 2, 1, 0);
        t_read("R7", 32'h0002_0014, 1, 1, 0, 0, 1);
        t_write("R7", 32'h0002_0018, 0);
        // R6: relocate window
        t_cfg(20'hFFFFF, 1, 0, 0);
        t_read("R6", 32'hFFFF_F800, 0, 0, 0, 0, 1);
        t_read("R6", 32'h0002_0004, 0, 1, 1, 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule